// File: doc/BRIEF.md
# Masked Interrupt Request Aggregator

This block collects interrupt requests from up to eight device lines and merges them into one level-sensitive request toward the processor's interrupt router. Each line has a sticky pending bit that a device sets with a request vector and can withdraw with a clear vector. An enable set decides which pending lines may reach the output. Software reaches the block through a small byte-wide access port. It can read the pending bits, write a mask, and acknowledge one line by its index.

The output is kept as a registered "active" flag. The router therefore sees one post pulse when an interrupt episode starts and one clear pulse when it ends, however many lines join or leave in between. A second, cascaded controller slot exists only in the address map. Its mask write is accepted and discarded, and its read always returns zero. The block does not resolve priorities and does not produce vectors.

Top module: `irq_aggregator`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, the pending set is empty, every line is disabled, and `irq_out`, `irq_post`, `irq_clear`, `acc_err` and `rd_data` are zero.
- R2: On a clock edge, every line with `dev_set` high becomes pending. Every line with `dev_clr` high and `dev_set` low stops pending. When both are high for the same line, the request wins.
- R3: A byte write (`acc_size`=0) to address 1 loads the enable set with the bitwise complement of `acc_wdata`, so a written 1 disables that line.
- R4: After each clock edge, `irq_out` is high exactly when at least one line is both pending and enabled, taking into account every change applied at that edge.
- R5: `irq_post` is high for one cycle, on the cycle in which `irq_out` rises. `irq_clear` is high for one cycle, on the cycle in which `irq_out` falls. The two are never high together.
- R6: A byte write to address 0 is an end-of-interrupt. It clears the pending bit whose index equals `acc_wdata[3:0]`. Indices 8 to 15 have no effect.
- R7: A read of address 0 with `acc_size` 0 (byte) or 3 (64-bit) returns, on the next cycle, the pending set before that edge in `rd_data[7:0]`, with all upper bits zero.
- R8: A byte read of address 2 returns zero. A byte write to address 3 is accepted without error and changes neither the pending set, the enables nor the output.
- R9: Any other access pulses `acc_err` on the next cycle, returns zero data and changes no state. This covers sizes 1 or 2, a write of a size other than 0, a 64-bit read of an address other than 0, and a read of address 1 or 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 2 | 0 pending/EOI, 1 mask, 2 secondary data, 3 secondary mask |
| acc_size | input | 2 | 0 byte, 1 half, 2 word, 3 doubleword |
| acc_wdata | input | 8 | Write data |
| rd_data | output | 64 | Read data, one cycle after the access |
| acc_err | output | 1 | Invalid access flag, one cycle after the access |
| dev_set | input | N_LINES | Device request vector |
| dev_clr | input | N_LINES | Device withdraw vector |
| irq_out | output | 1 | Level request to the router |
| irq_post | output | 1 | One-cycle pulse at the start of an episode |
| irq_clear | output | 1 | One-cycle pulse at the end of an episode |

## Verification
The bench builds the block with its default of eight lines and a 64-bit read path. At that width every end-of-interrupt index from 0 to 15 can be tried, so the out-of-range indices 8 to 15 get tested as well as the valid ones. Every mask byte can reach the enable set unaltered. Directed phases cover simultaneous set and clear on one line, mask changes that start or end an episode with no pending change, and each invalid access shape. A long random phase then mixes device traffic and accesses against a behavioural model on every clock.

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int N_LINES = 8,
  parameter int RD_W    = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_valid,
  input  logic               acc_write,
  input  logic [1:0]         acc_addr,
  input  logic [1:0]         acc_size,
  input  logic [7:0]         acc_wdata,
  output logic [RD_W-1:0]    rd_data,
  output logic               acc_err,
  input  logic [N_LINES-1:0] dev_set,
  input  logic [N_LINES-1:0] dev_clr,
  output logic               irq_out,
  output logic               irq_post,
  output logic               irq_clear
);

  localparam logic [1:0] A_CMD  = 2'd0;
  localparam logic [1:0] A_MASK = 2'd1;
  localparam logic [1:0] A_SDAT = 2'd2;
  localparam logic [1:0] SZ_B   = 2'd0;
  localparam logic [1:0] SZ_D   = 2'd3;

  logic [N_LINES-1:0] pend_q, en_q, pend_n, en_n, eoi_vec;
  logic act_q, act_n, rd_ok, wr_ok;

  assign rd_ok = acc_valid && !acc_write &&
                 ((acc_addr == A_CMD && (acc_size == SZ_B || acc_size == SZ_D)) ||
                  (acc_addr == A_SDAT && acc_size == SZ_B));
  assign wr_ok = acc_valid && acc_write && acc_size == SZ_B;

  assign eoi_vec = (wr_ok && acc_addr == A_CMD) ?
                   ({{(N_LINES-1){1'b0}}, 1'b1} << acc_wdata[3:0]) : '0;
  assign en_n    = (wr_ok && acc_addr == A_MASK) ? ~acc_wdata[N_LINES-1:0] : en_q;
  assign pend_n  = (pend_q & ~dev_clr & ~eoi_vec) | dev_set;
  assign act_n   = |(pend_n & en_n);
  assign irq_out = act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q    <= '0;
      en_q      <= '0;
      act_q     <= 1'b0;
      irq_post  <= 1'b0;
      irq_clear <= 1'b0;
      rd_data   <= '0;
      acc_err   <= 1'b0;
    end else begin
      pend_q    <= pend_n;
      en_q      <= en_n;
      act_q     <= act_n;
      irq_post  <= act_n && !act_q;
      irq_clear <= !act_n && act_q;
      rd_data   <= (rd_ok && acc_addr == A_CMD) ? RD_W'(pend_q) : '0;
      acc_err   <= acc_valid && !(rd_ok || wr_ok);
    end
  end

  assert_set_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|dev_set) |=> ((pend_q & $past(dev_set)) == $past(dev_set)));

  assert_mask_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_addr == A_MASK && acc_size == SZ_B)
    |=> (en_q == ~$past(acc_wdata[N_LINES-1:0])));

  assert_post_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_post |-> (irq_out && !$past(irq_out)));

  assert_clear_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clear |-> (!irq_out && $past(irq_out)));

  assert_pulse_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_post && irq_clear));

  assert_sec_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && acc_addr == A_SDAT && acc_size == SZ_B)
    |=> (rd_data == '0 && !acc_err));

  assert_bad_size_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && (acc_size == 2'd1 || acc_size == 2'd2)) |=> acc_err);

endmodule

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic v = 1'b0, w = 1'b0;
  logic [1:0] a = '0, s = '0;
  logic [7:0] wd = '0, dset = '0, dclr = '0;
  logic [63:0] rd_data;
  logic acc_err, irq_out, irq_post, irq_clear;

  int checks = 0, fails = 0, ncyc = 0;
  logic [7:0] m_pend = '0, m_en = '0;
  logic m_act = 1'b0, m_post = 1'b0, m_clr = 1'b0, m_err = 1'b0;
  logic [63:0] m_rd = '0;

  always #10 clk = ~clk;

  irq_aggregator u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(v), .acc_write(w), .acc_addr(a),
    .acc_size(s), .acc_wdata(wd), .rd_data(rd_data), .acc_err(acc_err),
    .dev_set(dset), .dev_clr(dclr), .irq_out(irq_out), .irq_post(irq_post),
    .irq_clear(irq_clear)
  );

  task automatic chk(string tag, string nm, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, nm, got, exp);
    end
  endtask

  task automatic step(string tag);
    logic rok, wok;
    logic [7:0] eoi;
    @(posedge clk);
    ncyc++;
    if (!rst_n) begin
      m_pend = '0; m_en = '0; m_act = 0; m_post = 0; m_clr = 0; m_err = 0; m_rd = '0;
    end else begin
      rok = v && !w && ((a == 0 && (s == 0 || s == 3)) || (a == 2 && s == 0));
      wok = v && w && s == 0;
      m_err = v && !(rok || wok);
      m_rd = (rok && a == 0) ? {56'd0, m_pend} : 64'd0;
      eoi = (wok && a == 0 && wd[3:0] < 8) ? (8'd1 << wd[3:0]) : 8'd0;
      if (wok && a == 1) m_en = ~wd;
      m_pend = (m_pend & ~dclr & ~eoi) | dset;
      m_post = ((m_pend & m_en) != 0) && !m_act;
      m_clr  = ((m_pend & m_en) == 0) && m_act;
      m_act  = (m_pend & m_en) != 0;
    end
    @(negedge clk);
    chk(tag, "irq_out", irq_out, m_act);
    chk(tag, "irq_post", irq_post, m_post);
    chk(tag, "irq_clear", irq_clear, m_clr);
    chk(tag, "rd_data", rd_data, m_rd);
    chk(tag, "acc_err", acc_err, m_err);
  endtask

  task automatic idle();
    v = 0; w = 0; a = 0; s = 0; wd = 0; dset = 0; dclr = 0;
  endtask

  task automatic acc(string tag, logic wr, logic [1:0] ad, logic [1:0] sz, logic [7:0] d);
    v = 1; w = wr; a = ad; s = sz; wd = d;
    step(tag);
    idle();
    step(tag);
  endtask

  task automatic dev(string tag, logic [7:0] st, logic [7:0] cl);
    dset = st; dclr = cl;
    step(tag);
    idle();
    step(tag);
  endtask

  initial begin
    #(20 * 5000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", ncyc, 1500);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    for (int i = 0; i < 3; i++) step("R1");
    rst_n = 1;
    step("R1");
    acc("R1", 0, 0, 0, 0);
    // R2: set under full mask, then clear, then collision
    dev("R2", 8'h05, 8'h00);
    acc("R7", 0, 0, 0, 0);
    dev("R2", 8'h00, 8'h01);
    dev("R2", 8'h04, 8'h04);
    acc("R2", 0, 0, 0, 0);
    // R3/R4/R5: mask opens and closes episodes
    acc("R3", 1, 1, 0, 8'hFE);
    acc("R4", 1, 1, 0, 8'hFB);
    dev("R5", 8'h01, 8'h00);
    // R8: secondary mask write and read
    acc("R8", 1, 3, 0, 8'h00);
    acc("R8", 0, 2, 0, 0);
    // R6: EOI
    acc("R6", 1, 0, 0, 8'h09);
    acc("R6", 1, 0, 0, 8'h02);
    acc("R6", 1, 0, 0, 8'h00);
    acc("R7", 0, 0, 3, 0);
    // R9: invalid accesses
    dev("R9", 8'hC0, 8'h00);
    acc("R9", 1, 1, 3, 8'h00);
    acc("R9", 0, 0, 1, 0);
    acc("R9", 0, 0, 2, 0);
    acc("R9", 0, 1, 0, 0);
    acc("R9", 0, 2, 3, 0);
    acc("R9", 1, 0, 2, 8'h06);
    acc("R7", 0, 0, 0, 0);
    // random mix
    for (int i = 0; i < 1200; i++) begin
      v = ($urandom % 3) == 0; w = $urandom; a = $urandom; s = ($urandom % 4 == 0) ? $urandom : 0;
      wd = $urandom;
      dset = ($urandom % 4 == 0) ? (8'd1 << ($urandom % 8)) : 0;
      dclr = ($urandom % 4 == 0) ? $urandom : 0;
      step("R4");
    end
    idle();
    step("R4");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule